// File: doc/BRIEF.md
# Processor Status Word Switch Sequencer

This block carries out the state switch a processor makes when it takes an interrupt, a trap or a supervisor call. When it accepts a cause, it writes the live 32-bit status word to a save slot in memory and then reads a replacement word from the load slot that belongs to the same cause level. It then puts that replacement into the status register in a single cycle. From acceptance to commit it cannot be interrupted. It ignores further causes, and it ignores the core's own writes to the status word, until the sequence has finished.

Each level has its own pair of adjacent memory words. The save slot is at `SLOT_BASE + 2*level` and the load slot is one word above it. An interrupt is accepted only at an interruptible point, or while the status word shows the waiting state, and only if its level is enabled in the mask field. Traps and supervisor calls are synchronous to the instruction being executed. The block takes them without regard to the mask or the boundary qualifier, but not while the processor is waiting, because in that state only an interrupt can wake it.

The controller has four named states. IDLE accepts a cause and moves to STORE. STORE issues the write and stays until `mem_ready`, then moves to LOAD. LOAD issues the read and stays until `mem_ready`, capturing the returned word, then moves to COMMIT. COMMIT copies the captured word into the status register, pulses `done`, and returns to IDLE.

Top module: `psw_switch_seq`

## Requirements
- R1: After reset, `psw_q` equals `RESET_PSW` (default 0x0004_0000), `busy`, `done` and `mem_req` are low, and the state is IDLE. A reset in the middle of a sequence aborts it with the same result.
- R2: The status word layout is: program counter in bits 15:0, condition code in 17:16, privileged mode in bit 18, waiting in bit 19, and a level-enable mask in 27:20, where bit 20+L enables level L. An interrupt cause (`cause_kind` = 2'b00) is accepted only if mask bit L is 1 and either `at_boundary` is high or the waiting bit is 1.
- R3: A trap (`cause_kind` = 2'b01) or supervisor call (2'b10) is accepted regardless of the mask and `at_boundary` when the waiting bit is 0, and is ignored when it is 1. The code 2'b11 is never accepted.
- R4: The first memory access of an accepted cause is a write (`mem_we`=1) to address `SLOT_BASE + 2*level`. Its data is the status word as it stood in the acceptance cycle.
- R5: After the write is acknowledged, the block issues exactly one read (`mem_we`=0) from `SLOT_BASE + 2*level + 1`.
- R6: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R7: `busy` is high from the cycle after acceptance through the COMMIT cycle. During that window, new causes and `psw_wr_en` have no effect and `psw_q` does not change.
- R8: When the read is acknowledged, the next cycle is COMMIT. In that cycle `done` is high for exactly one cycle, and at its end `psw_q` takes the word returned by the read.
- R9: When idle and no cause is accepted in the same cycle, `psw_wr_en` loads `psw_wr_data` into `psw_q` at the next edge. In the acceptance cycle the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cause_valid | input | 1 | A cause is presented this cycle |
| cause_kind | input | 2 | 00 interrupt, 01 trap, 10 supervisor call, 11 reserved |
| cause_level | input | LVL_W | Level selecting the slot pair and mask bit |
| at_boundary | input | 1 | Core is at an interruptible point |
| psw_wr_en | input | 1 | Core write strobe for the status word |
| psw_wr_data | input | 32 | Core write data for the status word |
| psw_q | output | 32 | Live status word |
| busy | output | 1 | Switch sequence in progress |
| done | output | 1 | One-cycle pulse in the commit cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
On every cycle, the assertions check the state order STORE, LOAD, COMMIT, IDLE. They also check that requests hold steady under wait states, that the status word is frozen while busy, that `done` is a single-cycle pulse, and the acceptance rules for traps and masked interrupts. The bench's scenarios show what the assertions cannot: the exact save and load addresses for each level, that the saved data is the pre-switch word, which word ends up committed, the waiting-state wake-up, and that a write or cause arriving mid-sequence leaves no trace.

// File: rtl/psw_sw_pkg.sv
package psw_sw_pkg;

    localparam int PSW_W        = 32;
    localparam int PSW_WAIT_BIT = 19;
    localparam int PSW_MASK_LSB = 20;
    localparam int PSW_MASK_W   = 8;

    typedef enum logic [1:0] {
        CK_INTR = 2'b00,
        CK_TRAP = 2'b01,
        CK_SVC  = 2'b10,
        CK_RSVD = 2'b11
    } cause_kind_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'b00,
        S_STORE  = 2'b01,
        S_LOAD   = 2'b10,
        S_COMMIT = 2'b11
    } sw_state_e;

endpackage

// File: rtl/psw_cause_gate.sv
module psw_cause_gate
    import psw_sw_pkg::*;
#(
    parameter int LEVELS = 8,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              cause_valid,
    input  logic [1:0]        cause_kind,
    input  logic [LVL_W-1:0]  cause_level,
    input  logic              at_boundary,
    input  logic              waiting,
    input  logic [LEVELS-1:0] level_mask,
    input  logic              idle,
    output logic              accept
);

    logic [LEVELS-1:0] lvl_hit;
    logic              level_enabled;
    logic              kind_ok;
    cause_kind_e       kind_e;

    // one-hot decode of the level so the mask lookup is a plain AND-OR
    for (genvar g = 0; g < LEVELS; g++) begin : g_hit
        assign lvl_hit[g] = (cause_level == LVL_W'(g));
    end

    assign level_enabled = |(lvl_hit & level_mask);
    assign kind_e        = cause_kind_e'(cause_kind);

    always_comb begin
        kind_ok = 1'b0;
        unique case (kind_e)
            CK_INTR: kind_ok = level_enabled && (at_boundary || waiting);
            CK_TRAP: kind_ok = !waiting;
            CK_SVC:  kind_ok = !waiting;
            CK_RSVD: kind_ok = 1'b0;
        endcase
    end

    assign accept = cause_valid && idle && kind_ok;

endmodule

// File: rtl/psw_slot_addr.sv
module psw_slot_addr #(
    parameter int          AW        = 16,
    parameter int          LVL_W     = 3,
    parameter logic [AW-1:0] SLOT_BASE = 16'h0100
) (
    input  logic [LVL_W-1:0] level,
    output logic [AW-1:0]    save_addr,
    output logic [AW-1:0]    load_addr
);

    logic [AW-1:0] pair_off;

    assign pair_off  = AW'(level) << 1;
    assign save_addr = SLOT_BASE + pair_off;
    assign load_addr = SLOT_BASE + (pair_off | AW'(1));

endmodule

// File: rtl/psw_sw_fsm.sv
module psw_sw_fsm
    import psw_sw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  logic      mem_ready,
    output sw_state_e state,
    output logic      busy,
    output logic      done,
    output logic      mem_req,
    output logic      mem_we,
    output logic      capture,
    output logic      commit
);

    sw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept)    state_d = S_STORE;
            S_STORE:  if (mem_ready) state_d = S_LOAD;
            S_LOAD:   if (mem_ready) state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        capture = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_STORE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_LOAD: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                capture = mem_ready;
            end
            S_COMMIT: begin
                busy   = 1'b1;
                done   = 1'b1;
                commit = 1'b1;
            end
        endcase
    end

    assign state = state_q;

    // R5: an acknowledged store is always followed by the load
    p_store_to_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STORE && mem_ready) |=> (state_q == S_LOAD));

    // R8: an acknowledged load is followed by commit, which lasts one cycle
    p_load_to_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD && mem_ready) |=> (state_q == S_COMMIT));

    p_commit_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |=> (state_q == S_IDLE));

    // R1: no memory traffic from the idle state
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !mem_req);

endmodule

// File: rtl/psw_switch_seq.sv
module psw_switch_seq
    import psw_sw_pkg::*;
#(
    parameter int            LEVELS    = 8,
    parameter int            AW        = 16,
    parameter logic [AW-1:0] SLOT_BASE = 16'h0100,
    parameter logic [31:0]   RESET_PSW = 32'h0004_0000,
    localparam int           LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cause_valid,
    input  logic [1:0]       cause_kind,
    input  logic [LVL_W-1:0] cause_level,
    input  logic             at_boundary,
    input  logic             psw_wr_en,
    input  logic [31:0]      psw_wr_data,
    output logic [31:0]      psw_q,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ready
);

    sw_state_e         state;
    logic              accept;
    logic              capture;
    logic              commit;
    logic [LVL_W-1:0]  level_q;
    logic [31:0]       load_buf;
    logic [AW-1:0]     save_addr;
    logic [AW-1:0]     load_addr;
    logic [LEVELS-1:0] level_mask;

    assign level_mask = psw_q[PSW_MASK_LSB +: LEVELS];

    psw_cause_gate #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_gate (
        .cause_valid (cause_valid),
        .cause_kind  (cause_kind),
        .cause_level (cause_level),
        .at_boundary (at_boundary),
        .waiting     (psw_q[PSW_WAIT_BIT]),
        .level_mask  (level_mask),
        .idle        (state == S_IDLE),
        .accept      (accept)
    );

    psw_sw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .mem_ready (mem_ready),
        .state     (state),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .capture   (capture),
        .commit    (commit)
    );

    psw_slot_addr #(.AW(AW), .LVL_W(LVL_W), .SLOT_BASE(SLOT_BASE)) u_addr (
        .level     (level_q),
        .save_addr (save_addr),
        .load_addr (load_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      level_q <= '0;
        else if (accept) level_q <= cause_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       load_buf <= '0;
        else if (capture) load_buf <= mem_rdata;
    end

    // the core's write port is frozen once a switch is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             psw_q <= RESET_PSW;
        else if (commit)                        psw_q <= load_buf;
        else if (psw_wr_en && !busy && !accept) psw_q <= psw_wr_data;
    end

    assign mem_addr  = mem_we ? save_addr : load_addr;
    assign mem_wdata = psw_q;

    // R6: an outstanding access holds still until acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

    // R7: the status word cannot move before commit
    p_psw_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(psw_q));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a trap outside the waiting state always starts a sequence
    p_trap_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cause_valid && cause_kind == 2'b01 && !psw_q[PSW_WAIT_BIT]) |=> busy);

    // R2: a masked interrupt never starts a sequence
    p_mask_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cause_valid && cause_kind == 2'b00
         && !level_mask[cause_level]) |=> !busy);

endmodule

// File: tb/tb_psw_switch_seq.sv
`timescale 1ns/1ps
module tb_psw_switch_seq;

    localparam logic [15:0] BASE = 16'h0100;
    localparam logic [31:0] RST_PSW = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cause_valid = 1'b0;
    logic [1:0]  cause_kind = 2'b00;
    logic [2:0]  cause_level = 3'd0;
    logic        at_boundary = 1'b0;
    logic        psw_wr_en = 1'b0;
    logic [31:0] psw_wr_data = '0;
    logic [31:0] psw_q;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    psw_switch_seq dut (
        .clk(clk), .rst_n(rst_n),
        .cause_valid(cause_valid), .cause_kind(cause_kind),
        .cause_level(cause_level), .at_boundary(at_boundary),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data),
        .psw_q(psw_q), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model: acknowledges after wait_cfg idle cycles, logs accesses
    int          wait_cfg = 0;
    int          wcnt = 0;
    int          n_wr = 0, n_rd = 0;
    logic [15:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;

    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= wait_cfg) begin
                mem_ready = 1'b1;
                wcnt = 0;
                if (mem_we) begin
                    wr_addr = mem_addr; wr_data = mem_wdata; n_wr++;
                end else begin
                    rd_addr = mem_addr; n_rd++;
                end
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // {kind[2], level[3], boundary, take, psw_init[32], load_word[32]}
    localparam int NV = 10;
    localparam logic [70:0] VEC [NV] = '{
        {2'd0, 3'd3, 1'b1, 1'b1, 32'h0080_1234, 32'h0F00_2000},  // R2 enabled at boundary
        {2'd0, 3'd3, 1'b1, 1'b0, 32'h0070_1234, 32'h0F00_2001},  // R2 masked
        {2'd0, 3'd5, 1'b0, 1'b0, 32'h0200_0042, 32'h0F00_2002},  // R2 not at boundary
        {2'd0, 3'd5, 1'b0, 1'b1, 32'h0208_0042, 32'h0F04_2003},  // R2 waiting wake-up
        {2'd1, 3'd1, 1'b0, 1'b1, 32'h0000_5555, 32'h0FF4_2004},  // R3 trap ignores mask
        {2'd2, 3'd7, 1'b1, 1'b1, 32'h0003_0100, 32'h0FF4_2005},  // R3 svc
        {2'd1, 3'd2, 1'b1, 1'b0, 32'h0FF8_0000, 32'h0F00_2006},  // R3 trap while waiting
        {2'd2, 3'd0, 1'b1, 1'b0, 32'h0FF8_0000, 32'h0F00_2007},  // R3 svc while waiting
        {2'd3, 3'd4, 1'b1, 1'b0, 32'h0FF0_0000, 32'h0F00_2008},  // R3 reserved code
        {2'd0, 3'd0, 1'b1, 1'b1, 32'h0010_00AA, 32'h0F00_2009}   // R2 level 0
    };

    task automatic set_psw(input logic [31:0] v);
        @(negedge clk); psw_wr_en = 1'b1; psw_wr_data = v;
        @(negedge clk); psw_wr_en = 1'b0;
        check(psw_q == v, "R9 psw write", psw_q, v);
    endtask

    task automatic wait_done();
        for (int k = 0; k < 40 && !done; k++) @(negedge clk);
    endtask

    initial begin : main
        logic [1:0]  kd;
        logic [2:0]  lv;
        logic        bd, tk;
        logic [31:0] pi, ld;

        repeat (3) @(negedge clk);
        check(psw_q == RST_PSW, "R1 reset psw", psw_q, RST_PSW);
        check(!busy && !done && !mem_req, "R1 reset outputs",
              {29'd0, busy, done, mem_req}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {kd, lv, bd, tk, pi, ld} = VEC[i];
            wait_cfg = i % 3;
            set_psw(pi);
            n_wr = 0; n_rd = 0; mem_rdata = ld;
            @(negedge clk);
            cause_valid = 1'b1; cause_kind = kd; cause_level = lv; at_boundary = bd;
            @(negedge clk);
            cause_valid = 1'b0; at_boundary = 1'b0;
            check(busy == tk, $sformatf("R2/R3 accept vec %0d", i), 32'(busy), 32'(tk));
            if (tk) begin
                wait_done();
                check(done && psw_q == pi, "R8 psw unchanged in commit cycle", psw_q, pi);
                check(n_wr == 1 && wr_addr == BASE + 16'(2 * lv), "R4 save address",
                      32'(wr_addr), 32'(BASE + 16'(2 * lv)));
                check(wr_data == pi, "R4 saved word", wr_data, pi);
                check(n_rd == 1 && rd_addr == BASE + 16'(2 * lv + 1), "R5 load address",
                      32'(rd_addr), 32'(BASE + 16'(2 * lv + 1)));
                @(negedge clk);
                check(psw_q == ld && !busy && !done, "R8 committed word", psw_q, ld);
            end else begin
                repeat (3) @(negedge clk);
                check(psw_q == pi && n_wr == 0 && n_rd == 0 && !busy,
                      "R2/R3 ignored cause leaves state", psw_q, pi);
            end
        end

        // R7: cause and psw write during a sequence have no effect
        wait_cfg = 3;
        set_psw(32'h0080_0011);
        n_wr = 0; n_rd = 0; mem_rdata = 32'h0A0B_0C0D;
        @(negedge clk);
        cause_valid = 1'b1; cause_kind = 2'b00; cause_level = 3'd3; at_boundary = 1'b1;
        @(negedge clk);
        cause_kind = 2'b01; cause_level = 3'd6; psw_wr_en = 1'b1; psw_wr_data = 32'h0000_DEAD;
        @(negedge clk);
        cause_valid = 1'b0; psw_wr_en = 1'b0; at_boundary = 1'b0;
        check(psw_q == 32'h0080_0011, "R7 write port frozen", psw_q, 32'h0080_0011);
        wait_done();
        check(wr_addr == BASE + 16'd6 && wr_data == 32'h0080_0011, "R7 first cause kept",
              32'(wr_addr), 32'(BASE + 16'd6));
        @(negedge clk);
        check(psw_q == 32'h0A0B_0C0D, "R7 commit after ignored inputs", psw_q, 32'h0A0B_0C0D);
        repeat (3) @(negedge clk);
        check(!busy && n_wr == 1 && n_rd == 1, "R7 no second sequence",
              32'(n_wr + n_rd), 32'd2);

        // R9: write in the acceptance cycle is dropped
        wait_cfg = 0;
        set_psw(32'h0000_0777);
        @(negedge clk);
        cause_valid = 1'b1; cause_kind = 2'b01; cause_level = 3'd1;
        psw_wr_en = 1'b1; psw_wr_data = 32'h0000_0999;
        @(negedge clk);
        cause_valid = 1'b0; psw_wr_en = 1'b0;
        check(psw_q == 32'h0000_0777, "R9 write dropped on accept", psw_q, 32'h0000_0777);
        wait_done();
        @(negedge clk);

        // R1: reset in mid-sequence
        wait_cfg = 5;
        set_psw(32'h0000_1111);
        @(negedge clk);
        cause_valid = 1'b1; cause_kind = 2'b10; cause_level = 3'd2;
        @(negedge clk);
        cause_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(psw_q == RST_PSW && !busy && !mem_req, "R1 reset aborts sequence", psw_q, RST_PSW);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done, "R1 idle after reset", 32'(busy), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule